// File: doc/BRIEF.md
# Move-Only Transport-Triggered CPU Core

This block is an 8-bit processor with a single instruction: move one byte from a source address to a destination address. Every functional unit hangs off one shared data bus behind its own enable buffer. The source and destination fields of the current instruction select exactly one driving buffer and one capturing register. Arithmetic and logic are side effects of moves. Software writes two operand registers, then reads a result port such as the adder or the XOR unit and moves that value wherever it is needed.

Control flow comes entirely from moves into the program counter. A move into the jump port always loads the program counter. A move into the conditional port loads it only when the first operand register holds zero. A literal operand sits in the program word after the move that uses it, and the sequencer steps over that word. The program store is outside the core, which presents two read addresses: the current instruction and the word after it.

Top module: `mover_core`

## Requirements
- R1: An instruction word carries the source address in bits [15:8] and the destination address in bits [7:0]. One move completes per clock: the destination register captures the bus value at the rising edge, and the program counter then advances to the next word.
- R2: The source addresses are 0x01 first operand register, 0x02 second operand register, 0x03 sum modulo 256, 0x04 first minus second modulo 256, 0x05 bitwise AND, 0x06 bitwise OR, 0x07 bitwise XOR, and 0x08 literal.
- R3: The destination addresses are 0x01 first operand register, 0x02 second operand register, 0x03 jump, 0x04 jump-if-zero and 0x05 output register.
- R4: The literal is the low byte of the word at program counter + 1. When the source is 0x08 and no jump is taken, the program counter advances by 2. Otherwise it advances by 1.
- R5: A move to the jump destination loads the program counter with the bus value, with no condition.
- R6: A move to the jump-if-zero destination loads the program counter with the bus value when the first operand register is 0x00. Otherwise the program counter advances as in R4.
- R7: A source address that is not mapped leaves the bus undriven, and the bus then reads 0x00.
- R8: A move to a destination address that is not mapped changes no register except the program counter, which advances as in R4.
- R9: While the active-low reset is low, the program counter, both operand registers and the output register are cleared at once. After release, execution starts at address 0 on the third rising edge.
- R10: At most one source buffer is enabled in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_i | input | 16 | Program word at address pc_o |
| imm_word_i | input | 8 | Low byte of the program word at address imm_addr_o |
| pc_o | output | 8 | Program counter, the fetch address |
| imm_addr_o | output | 8 | Fetch address of the literal, pc_o + 1 |
| acc0_o | output | 8 | First operand register |
| acc1_o | output | 8 | Second operand register |
| out_o | output | 8 | Output register, written through destination 0x05 |

## Verification
The assertions check the following on every cycle: that at most one source buffer is enabled, that an undriven bus reads zero, and that the sequencer takes the right program counter step. That step is +1 or +2, a jump, or a conditional jump that falls through. The assertions also check that registers not addressed as the destination hold their value, and that reset clears the state. Only the bench's programs can show that the result ports compute the right values from real operands. The same holds for the literal byte being fetched from the next word, the taken branch of the conditional jump reaching the right target, and the exact edge on which execution starts after reset.

// File: rtl/mover_pkg.sv
package mover_pkg;
  // Source port addresses (buffer index = address - 1)
  localparam int SRC_ACC0 = 1;
  localparam int SRC_ACC1 = 2;
  localparam int SRC_ADD  = 3;
  localparam int SRC_SUB  = 4;
  localparam int SRC_AND  = 5;
  localparam int SRC_OR   = 6;
  localparam int SRC_XOR  = 7;
  localparam int SRC_IMM  = 8;
  localparam int NSRC     = 8;
  // Destination port addresses
  localparam int DST_ACC0 = 1;
  localparam int DST_ACC1 = 2;
  localparam int DST_JMP  = 3;
  localparam int DST_JZ   = 4;
  localparam int DST_OUT  = 5;
endpackage

// File: rtl/mover_rstsync.sv
module mover_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/mover_srcdec.sv
module mover_srcdec #(
  parameter int AW   = 8,
  parameter int NSRC = 8
) (
  input  logic [AW-1:0]   src,
  output logic [NSRC-1:0] src_en
);
  for (genvar g = 0; g < NSRC; g++) begin : g_dec
    assign src_en[g] = (src == AW'(g + 1));
  end
endmodule

// File: rtl/mover_units.sv
module mover_units #(
  parameter int DW   = 8,
  parameter int NSRC = 8
) (
  input  logic [DW-1:0]            acc0,
  input  logic [DW-1:0]            acc1,
  input  logic [DW-1:0]            imm,
  output logic [NSRC-1:0][DW-1:0]  val
);
  import mover_pkg::*;

  always_comb begin
    val                = '0;
    val[SRC_ACC0 - 1]  = acc0;
    val[SRC_ACC1 - 1]  = acc1;
    val[SRC_ADD - 1]   = acc0 + acc1;
    val[SRC_SUB - 1]   = acc0 - acc1;
    val[SRC_AND - 1]   = acc0 & acc1;
    val[SRC_OR - 1]    = acc0 | acc1;
    val[SRC_XOR - 1]   = acc0 ^ acc1;
    val[SRC_IMM - 1]   = imm;
  end
endmodule

// File: rtl/mover_bus.sv
module mover_bus #(
  parameter int DW   = 8,
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0]          src_en,
  input  logic [NSRC-1:0][DW-1:0]  val,
  output logic [DW-1:0]            bus
);
  logic [NSRC:0][DW-1:0] chain;

  assign chain[0] = '0;
  for (genvar g = 0; g < NSRC; g++) begin : g_buf
    assign chain[g+1] = chain[g] | (val[g] & {DW{src_en[g]}});
  end

  assign bus = chain[NSRC];
endmodule

// File: rtl/mover_seq.sv
module mover_seq #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic [AW-1:0] dst,
  input  logic          src_is_imm,
  input  logic          acc0_zero,
  input  logic [DW-1:0] bus,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] pc_inc
);
  import mover_pkg::*;

  logic [DW-1:0] pc_d;
  logic          take;

  assign pc_inc = pc + DW'(1);

  always_comb begin
    take = (dst == AW'(DST_JMP)) || ((dst == AW'(DST_JZ)) && acc0_zero);
    if (take)            pc_d = bus;
    else if (src_is_imm) pc_d = pc + DW'(2);
    else                 pc_d = pc_inc;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) pc <= '0;
    else        pc <= pc_d;
  end
endmodule

// File: rtl/mover_core.sv
module mover_core #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*AW-1:0] instr_i,
  input  logic [DW-1:0]   imm_word_i,
  output logic [DW-1:0]   pc_o,
  output logic [DW-1:0]   imm_addr_o,
  output logic [DW-1:0]   acc0_o,
  output logic [DW-1:0]   acc1_o,
  output logic [DW-1:0]   out_o
);
  import mover_pkg::*;

  logic                    rst_q;
  logic [AW-1:0]           src, dst;
  logic [NSRC-1:0]         src_en;
  logic [NSRC-1:0][DW-1:0] val;
  logic [DW-1:0]           bus;
  logic [DW-1:0]           acc0, acc1, out_q;
  logic [DW-1:0]           acc0_d, acc1_d, out_d;
  logic                    acc0_en, acc1_en, out_en;

  assign src = instr_i[2*AW-1:AW];
  assign dst = instr_i[AW-1:0];

  mover_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  mover_srcdec #(.AW(AW), .NSRC(NSRC)) u_dec (.src(src), .src_en(src_en));

  mover_units #(.DW(DW), .NSRC(NSRC)) u_units (
    .acc0(acc0), .acc1(acc1), .imm(imm_word_i), .val(val)
  );

  mover_bus #(.DW(DW), .NSRC(NSRC)) u_bus (.src_en(src_en), .val(val), .bus(bus));

  mover_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk(clk), .rst_q(rst_q), .dst(dst),
    .src_is_imm(src_en[SRC_IMM - 1]), .acc0_zero(acc0 == '0),
    .bus(bus), .pc(pc_o), .pc_inc(imm_addr_o)
  );

  always_comb begin
    acc0_en = (dst == AW'(DST_ACC0));
    acc1_en = (dst == AW'(DST_ACC1));
    out_en  = (dst == AW'(DST_OUT));
    acc0_d  = bus;
    acc1_d  = bus;
    out_d   = bus;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      acc0  <= '0;
      acc1  <= '0;
      out_q <= '0;
    end else begin
      if (acc0_en) acc0  <= acc0_d;
      if (acc1_en) acc1  <= acc1_d;
      if (out_en)  out_q <= out_d;
    end
  end

  assign acc0_o = acc0;
  assign acc1_o = acc1;
  assign out_o  = out_q;
endmodule

// File: rtl/mover_chk.sv
module mover_chk #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [AW-1:0] src,
  input logic [AW-1:0] dst,
  input logic [7:0]    src_en,
  input logic [DW-1:0] bus,
  input logic [DW-1:0] pc,
  input logic [DW-1:0] acc0,
  input logic [DW-1:0] acc1,
  input logic [DW-1:0] out_q
);
  import mover_pkg::*;

  logic is_jmp, is_jz, is_imm;
  assign is_jmp = (dst == AW'(DST_JMP));
  assign is_jz  = (dst == AW'(DST_JZ));
  assign is_imm = (src == AW'(SRC_IMM));

  // R10
  one_src_chk: assert property (@(posedge clk) disable iff (!run) $onehot0(src_en));

  // R7
  idle_bus_chk: assert property (@(posedge clk) disable iff (!run)
    (src_en == '0) |-> (bus == '0));

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!run)
    (!is_jmp && !is_jz && !is_imm) |=> (pc == $past(pc) + DW'(1)));

  // R4
  step_two_chk: assert property (@(posedge clk) disable iff (!run)
    (!is_jmp && !is_jz && is_imm) |=> (pc == $past(pc) + DW'(2)));

  // R5
  jump_chk: assert property (@(posedge clk) disable iff (!run)
    is_jmp |=> (pc == $past(bus)));

  // R6
  jz_taken_chk: assert property (@(posedge clk) disable iff (!run)
    (is_jz && acc0 == '0) |=> (pc == $past(bus)));

  // R6
  jz_fall_chk: assert property (@(posedge clk) disable iff (!run)
    (is_jz && acc0 != '0 && !is_imm) |=> (pc == $past(pc) + DW'(1)));

  // R8
  acc0_hold_chk: assert property (@(posedge clk) disable iff (!run)
    (dst != AW'(DST_ACC0)) |=> (acc0 == $past(acc0)));

  // R8
  acc1_hold_chk: assert property (@(posedge clk) disable iff (!run)
    (dst != AW'(DST_ACC1)) |=> (acc1 == $past(acc1)));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!run)
    (dst != AW'(DST_OUT)) |=> (out_q == $past(out_q)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pc == '0 && acc0 == '0 && acc1 == '0 && out_q == '0));
endmodule

bind mover_core mover_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(rst_q), .src(src), .dst(dst),
  .src_en(src_en), .bus(bus), .pc(pc_o), .acc0(acc0), .acc1(acc1), .out_q(out_q)
);

// File: tb/sim_mover_core.sv
module sim_mover_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rom [256];
  logic [15:0] instr;
  logic [7:0]  imm_word, pc, imm_addr, acc0, acc1, outv;
  int          n_run = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  assign instr    = rom[pc];
  assign imm_word = rom[imm_addr][7:0];

  mover_core u0 (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .imm_word_i(imm_word),
    .pc_o(pc), .imm_addr_o(imm_addr), .acc0_o(acc0), .acc1_o(acc1), .out_o(outv)
  );

  // {source op, operand a, operand b}
  localparam logic [23:0] VEC [10] = '{
    {8'h03, 8'h12, 8'h34}, {8'h03, 8'hFF, 8'h01}, {8'h04, 8'h50, 8'h20},
    {8'h04, 8'h00, 8'h01}, {8'h05, 8'hF0, 8'h3C}, {8'h06, 8'hF0, 8'h0F},
    {8'h07, 8'hAA, 8'hFF}, {8'h01, 8'h9C, 8'h11}, {8'h02, 8'h9C, 8'h11},
    {8'h05, 8'h00, 8'hFF}
  };

  function automatic logic [7:0] model(logic [7:0] op, logic [7:0] a, logic [7:0] b);
    case (op)
      8'h01: return a;
      8'h02: return b;
      8'h03: return a + b;
      8'h04: return a - b;
      8'h05: return a & b;
      8'h06: return a | b;
      8'h07: return a ^ b;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
  endtask

  task automatic restart();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    clear_rom();
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 pc", pc, 8'h00);
    chk("R9 acc0", acc0, 8'h00);
    chk("R9 out", outv, 8'h00);

    // R2 R3 R5: operand loads, result port, self-loop jump
    for (int v = 0; v < 10; v++) begin
      clear_rom();
      rom[0] = 16'h0801; rom[1] = {8'h00, VEC[v][15:8]};
      rom[2] = 16'h0802; rom[3] = {8'h00, VEC[v][7:0]};
      rom[4] = {VEC[v][23:16], 8'h05};
      rom[5] = 16'h0803; rom[6] = 16'h0005;
      restart();
      settle(14);
      chk("R2 result", outv, model(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]));
      chk("R3 acc0", acc0, VEC[v][15:8]);
      chk("R3 acc1", acc1, VEC[v][7:0]);
      chk("R5 loop", pc, 8'h05);
    end

    // R1 R4: exact stepping; literal move to unmapped destination skips a word
    clear_rom();
    rom[0] = 16'h0800; rom[1] = 16'h00FF;
    restart();
    settle(3);
    chk("R4 skip", pc, 8'h02);
    settle(1);
    chk("R1 step", pc, 8'h03);
    chk("R8 out untouched", outv, 8'h00);

    // R6 taken
    clear_rom();
    rom[0] = 16'h0801; rom[1] = 16'h0000;
    rom[2] = 16'h0804; rom[3] = 16'h000A;
    rom[4] = 16'h0805; rom[5] = 16'h0011;
    rom[6] = 16'h0803; rom[7] = 16'h0006;
    rom[10] = 16'h0805; rom[11] = 16'h00A5;
    rom[12] = 16'h0803; rom[13] = 16'h000C;
    restart();
    settle(14);
    chk("R6 taken", outv, 8'hA5);
    chk("R6 taken pc", pc, 8'h0C);

    // R6 not taken
    rom[1] = 16'h0003;
    restart();
    settle(14);
    chk("R6 fall", outv, 8'h11);
    chk("R6 fall pc", pc, 8'h06);

    // R8 unmapped destinations
    clear_rom();
    rom[0] = 16'h0801; rom[1] = 16'h0012;
    rom[2] = 16'h0802; rom[3] = 16'h0034;
    rom[4] = 16'h0840; rom[5] = 16'h0077;
    rom[6] = 16'h0100;
    rom[7] = 16'h0105;
    rom[8] = 16'h0803; rom[9] = 16'h0008;
    restart();
    settle(14);
    chk("R8 out", outv, 8'h12);
    chk("R8 acc0", acc0, 8'h12);
    chk("R8 acc1", acc1, 8'h34);

    // R9 asynchronous clear mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R9 async acc0", acc0, 8'h00);
    chk("R9 async out", outv, 8'h00);
    chk("R9 async pc", pc, 8'h00);

    // R7 undriven bus reads zero
    clear_rom();
    rom[0] = 16'h0805; rom[1] = 16'h0033;
    rom[2] = 16'h5005;
    rom[3] = 16'h0803; rom[4] = 16'h0003;
    restart();
    settle(3);
    chk("R7 preset", outv, 8'h33);
    settle(8);
    chk("R7 undriven", outv, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule